// File: doc/BRIEF.md
# TDM Time-Slot Switch with Connection Memory

This block switches bytes between time slots for one output direction of a time-division-multiplexed fabric. Every clock cycle is one channel slot. In each slot, the byte arriving on every local input lane and every backplane input lane is stored in a data memory. Each output lane then produces one byte for that slot. A per-lane, per-channel connection memory entry selects what the byte is. It can be a byte switched from any stream and channel on the local or the backplane side. It can also be a fixed message byte written by the CPU.

For switched bytes, each entry picks its own throughput delay. Constant delay gives exactly one frame. Variable delay uses the current frame when the source slot has already arrived. Sub-rate extraction can keep only one bit pair of the source byte.

The CPU writes entries into a shadow copy, and the shadow becomes active only at a frame boundary. A block-programming command sets the per-entry output-enable bit of every entry at once. After reset, nothing drives until either the output-drive-enable pin is high or software sets the output-enable control bit. This covers the fact that connection memory contents are undefined after reset.

Top module: `tsw_switch`

## Requirements
- R1: The slot counter starts at 0 after reset, counts up by one each cycle and wraps from NUM_CH-1 to 0. The output lanes show the result for slot c in the cycle after slot c, with `out_ch` equal to c.
- R2: A connection entry is 15 bits: bit 14 output enable, bit 13 message, bit 12 backplane select, bit 11 constant delay, bit 10 sub-rate enable, bits 9:8 sub-rate pair, bits 7:0 low part. With the message bit set, the lane outputs the low part unchanged.
- R3: With the message bit clear, low-part bits 4:0 name the source channel and bits 6:5 the source stream. Bit 12 = 1 takes the byte from the backplane inputs, 0 from the local inputs.
- R4: With bit 11 = 1 (constant delay), the switched byte is the source slot's byte from the previous frame.
- R5: With bit 11 = 0 (variable delay), a source channel lower than the output slot gives the byte from the current frame. Otherwise it gives the byte from the previous frame.
- R6: With bit 10 = 1, only source-byte bits 2p+1:2p are kept, where p is bits 9:8. All other bits are zero.
- R7: An entry with bit 14 = 0 gives `out_en` low and `out_data` zero for that lane and slot.
- R8: A lane drives only while `ode_in` is high or the software output-enable bit is set. The software bit is written through `cpu_ctl_we`/`cpu_ctl_oe` and cleared by reset.
- R9: A connection memory write becomes visible from the first frame boundary after it. Slots later in the same frame still use the old entry.
- R10: A block-programming write sets bit 14 of every entry to `cpu_wdata[14]`, leaving all other fields unchanged. It takes effect at the next frame boundary.
- R11: During and right after reset, `out_en` is all zero, `out_data` is zero and `out_ch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_in | input | NUM_STREAMS*8 | Local input bytes, lane s in bits 8s+7:8s |
| bp_in | input | NUM_STREAMS*8 | Backplane input bytes, same lane layout |
| ode_in | input | 1 | External output-drive enable |
| cpu_we | input | 1 | Write one connection entry |
| cpu_blk_we | input | 1 | Block-program the output-enable bit of all entries |
| cpu_addr | input | LANE_W+CA_W | Entry address: {output lane, channel} |
| cpu_wdata | input | 15 | Entry value (bit 14 also used by block programming) |
| cpu_ctl_we | input | 1 | Write the software output-enable bit |
| cpu_ctl_oe | input | 1 | Value for the software output-enable bit |
| out_data | output | NUM_STREAMS*8 | Output bytes per lane, zero when not driven |
| out_en | output | NUM_STREAMS | Per-lane drive enable for the presented slot |
| out_ch | output | CA_W | Slot index of the presented output |

## Verification
The bench builds the block with its defaults: four streams and 32 channels per frame. With these values, every field of the 15-bit entry is exercised at full width. That includes the 2-bit stream field up to stream 3 and source channels up to 31. A frame boundary comes every 32 cycles, so entry updates, block programming and both delay modes can each be seen across several consecutive frames. The last slot of a frame is included: its output appears during the next frame's slot 0. A variable-delay source at channel 31 read from slot 0 is also included, so the previous-frame path is exercised at both ends of the frame.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef struct packed {
    logic       oe;
    logic       msg;
    logic       bp;
    logic       cdly;
    logic       sr_en;
    logic [1:0] sr_pos;
    logic [7:0] lo;
  } cm_entry_t;

  localparam int ENTRY_W = $bits(cm_entry_t);

  // Bank that holds the wanted copy of a source slot.
  function automatic logic pick_bank(input logic cdly, input int src_ch,
                                     input int cur_ch, input logic wr_bank);
    if (cdly || (src_ch >= cur_ch)) return ~wr_bank;
    return wr_bank;
  endfunction

  // Keep one bit pair of a byte.
  function automatic logic [7:0] subrate_keep(input logic [7:0] b, input logic [1:0] pos);
    return b & (8'h03 << {pos, 1'b0});
  endfunction

endpackage

// File: rtl/tsw_slot_counter.sv
module tsw_slot_counter #(
  parameter int NUM_CH = 32,
  localparam int CA_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [CA_W-1:0] ch_o,
  output logic            wr_bank_o,
  output logic            frame_end_o
);

  localparam logic [CA_W-1:0] LAST = CA_W'(NUM_CH - 1);

  logic [CA_W-1:0] ch_q;
  logic            wr_bank_q;
  logic            frame_end;

  assign frame_end = (ch_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q      <= '0;
      wr_bank_q <= 1'b0;
    end else begin
      ch_q <= frame_end ? '0 : ch_q + 1'b1;
      if (frame_end) wr_bank_q <= ~wr_bank_q;
    end
  end

  assign ch_o        = ch_q;
  assign wr_bank_o   = wr_bank_q;
  assign frame_end_o = frame_end;

  AST_CH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_q == LAST) |=> (ch_q == '0));  // R1
  AST_CH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_q != LAST) |=> (ch_q == $past(ch_q) + 1'b1));  // R1
  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wr_bank_q != $past(wr_bank_q)));  // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(wr_bank_q));  // R4

endmodule

// File: rtl/tsw_conn_mem.sv
module tsw_conn_mem
  import tsw_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int NUM_CH    = 32,
  localparam int CA_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int ADDR_W = LANE_W + CA_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_end,
  input  logic                       cpu_we,
  input  logic                       cpu_blk_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  cm_entry_t                  cpu_wdata,
  input  logic [CA_W-1:0]            rd_ch,
  output cm_entry_t [NUM_LANES-1:0]  rd_ent
);

  // Shadow takes CPU writes; active is what the slots use.
  cm_entry_t [DEPTH-1:0] shd_q;
  cm_entry_t [DEPTH-1:0] act_q;

  always_ff @(posedge clk) begin
    if (cpu_blk_we) begin
      for (int i = 0; i < DEPTH; i++) shd_q[i].oe <= cpu_wdata.oe;
    end
    if (cpu_we) shd_q[cpu_addr] <= cpu_wdata;
    if (frame_end) act_q <= shd_q;
  end

  for (genvar o = 0; o < NUM_LANES; o++) begin : g_rd
    assign rd_ent[o] = act_q[{LANE_W'(o), rd_ch}];
  end

  AST_CM_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_q));  // R9

endmodule

// File: rtl/tsw_data_mem.sv
module tsw_data_mem #(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  parameter int NUM_PORTS   = 4,
  localparam int CA_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SA_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                                clk,
  input  logic                                wr_bank,
  input  logic [CA_W-1:0]                     wr_ch,
  input  logic [NUM_STREAMS-1:0][7:0]         din,
  input  logic [NUM_PORTS-1:0]                rd_bank,
  input  logic [NUM_PORTS-1:0][SA_W-1:0]      rd_str,
  input  logic [NUM_PORTS-1:0][CA_W-1:0]      rd_ch,
  output logic [NUM_PORTS-1:0][7:0]           dout
);

  logic [7:0] mem_q [2][NUM_STREAMS][NUM_CH];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_STREAMS; s++) mem_q[wr_bank][s][wr_ch] <= din[s];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assign dout[p] = mem_q[rd_bank[p]][rd_str[p]][rd_ch[p]];
  end

endmodule

// File: rtl/tsw_lane_out.sv
module tsw_lane_out
  import tsw_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  localparam int CA_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SA_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_en,
  input  logic [CA_W-1:0] cur_ch,
  input  logic            wr_bank,
  input  cm_entry_t       ent,
  input  logic [7:0]      loc_byte,
  input  logic [7:0]      bp_byte,
  output logic            rd_bank,
  output logic [SA_W-1:0] rd_str,
  output logic [CA_W-1:0] rd_ch,
  output logic [7:0]      data_q,
  output logic            en_q
);

  logic [7:0] sw_byte;
  logic [7:0] slot_byte;
  logic       drive_en;

  assign rd_ch   = ent.lo[CA_W-1:0];
  assign rd_str  = ent.lo[CA_W+SA_W-1:CA_W];
  assign rd_bank = pick_bank(ent.cdly, int'(rd_ch), int'(cur_ch), wr_bank);

  always_comb begin
    sw_byte = ent.bp ? bp_byte : loc_byte;
    if (ent.sr_en) sw_byte = subrate_keep(sw_byte, ent.sr_pos);
    slot_byte = ent.msg ? ent.lo : sw_byte;
  end

  assign drive_en = glob_en & ent.oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= drive_en;
      data_q <= drive_en ? slot_byte : '0;
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (data_q == '0));  // R7
  AST_ENTRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ent.oe |=> !en_q);  // R7
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !en_q);  // R8
  AST_MSG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && ent.oe && ent.msg) |=> (data_q == $past(ent.lo)));  // R2

endmodule

// File: rtl/tsw_switch.sv
module tsw_switch
  import tsw_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 32,
  localparam int CA_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SA_W   = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int LANE_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int ADDR_W = LANE_W + CA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_STREAMS*8-1:0] loc_in,
  input  logic [NUM_STREAMS*8-1:0] bp_in,
  input  logic                     ode_in,
  input  logic                     cpu_we,
  input  logic                     cpu_blk_we,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [ENTRY_W-1:0]       cpu_wdata,
  input  logic                     cpu_ctl_we,
  input  logic                     cpu_ctl_oe,
  output logic [NUM_STREAMS*8-1:0] out_data,
  output logic [NUM_STREAMS-1:0]   out_en,
  output logic [CA_W-1:0]          out_ch
);

  logic [CA_W-1:0] ch;
  logic            wr_bank;
  logic            frame_end;
  logic            sw_oe_q;
  logic            glob_en;
  logic [CA_W-1:0] out_ch_q;

  cm_entry_t [NUM_STREAMS-1:0]           ent;
  logic [NUM_STREAMS-1:0][7:0]           loc_arr, bp_arr;
  logic [NUM_STREAMS-1:0]                rd_bank;
  logic [NUM_STREAMS-1:0][SA_W-1:0]      rd_str;
  logic [NUM_STREAMS-1:0][CA_W-1:0]      rd_ch;
  logic [NUM_STREAMS-1:0][7:0]           loc_rd, bp_rd;
  logic [NUM_STREAMS-1:0][7:0]           lane_data;
  logic [NUM_STREAMS-1:0]                lane_en;

  assign loc_arr = loc_in;
  assign bp_arr  = bp_in;
  assign glob_en = ode_in | sw_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_oe_q  <= 1'b0;
      out_ch_q <= '0;
    end else begin
      if (cpu_ctl_we) sw_oe_q <= cpu_ctl_oe;
      out_ch_q <= ch;
    end
  end

  tsw_slot_counter #(.NUM_CH(NUM_CH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ch_o(ch), .wr_bank_o(wr_bank), .frame_end_o(frame_end)
  );

  tsw_conn_mem #(.NUM_LANES(NUM_STREAMS), .NUM_CH(NUM_CH)) u_cm (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
    .cpu_we(cpu_we), .cpu_blk_we(cpu_blk_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cm_entry_t'(cpu_wdata)), .rd_ch(ch), .rd_ent(ent)
  );

  tsw_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .NUM_PORTS(NUM_STREAMS)) u_dm_loc (
    .clk(clk), .wr_bank(wr_bank), .wr_ch(ch), .din(loc_arr),
    .rd_bank(rd_bank), .rd_str(rd_str), .rd_ch(rd_ch), .dout(loc_rd)
  );

  tsw_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .NUM_PORTS(NUM_STREAMS)) u_dm_bp (
    .clk(clk), .wr_bank(wr_bank), .wr_ch(ch), .din(bp_arr),
    .rd_bank(rd_bank), .rd_str(rd_str), .rd_ch(rd_ch), .dout(bp_rd)
  );

  for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_lane
    tsw_lane_out #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) u_lane (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cur_ch(ch), .wr_bank(wr_bank),
      .ent(ent[o]), .loc_byte(loc_rd[o]), .bp_byte(bp_rd[o]),
      .rd_bank(rd_bank[o]), .rd_str(rd_str[o]), .rd_ch(rd_ch[o]),
      .data_q(lane_data[o]), .en_q(lane_en[o])
    );
  end

  assign out_data = lane_data;
  assign out_en   = lane_en;
  assign out_ch   = out_ch_q;

endmodule

// File: tb/tsw_switch_test.sv
module tsw_switch_test;
  localparam int NS  = 4;
  localparam int NCH = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic [NS*8-1:0] loc_in, bp_in;
  logic           ode_in, cpu_we, cpu_blk_we, cpu_ctl_we, cpu_ctl_oe;
  logic [6:0]     cpu_addr;
  logic [14:0]    cpu_wdata;
  logic [NS*8-1:0] out_data;
  logic [NS-1:0]  out_en;
  logic [4:0]     out_ch;

  tsw_switch #(.NUM_STREAMS(NS), .NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .loc_in(loc_in), .bp_in(bp_in), .ode_in(ode_in),
    .cpu_we(cpu_we), .cpu_blk_we(cpu_blk_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ctl_we(cpu_ctl_we), .cpu_ctl_oe(cpu_ctl_oe),
    .out_data(out_data), .out_en(out_en), .out_ch(out_ch)
  );

  int checks = 0;
  int errors = 0;
  int tb_ch, tb_frame;
  bit finished = 0;

  // Entry bits: {oe, msg, bp, cdly, sr_en, sr_pos[1:0], lo[7:0]}, lo = {x, stream[1:0], ch[4:0]}
  typedef struct packed {
    logic [1:0]  lane;
    logic [4:0]  ch;
    logic [14:0] ent;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 5'd5,  {1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'h3C}},            // R2 message
    '{2'd1, 5'd10, {1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,2'd2,5'd20}},  // R4 constant, local
    '{2'd2, 5'd10, {1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd1,5'd3}},   // R5 variable, earlier source
    '{2'd3, 5'd10, {1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,5'd10}},  // R5 variable, same slot
    '{2'd0, 5'd12, {1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd3,5'd31}},  // R3 backplane constant
    '{2'd1, 5'd20, {1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,2'd2,5'd19}},  // R3 backplane variable
    '{2'd2, 5'd25, {1'b1,1'b0,1'b0,1'b1,1'b1,2'd2,1'b0,2'd1,5'd7}},   // R6 sub-rate pair 2
    '{2'd3, 5'd31, {1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd3,5'd30}},  // R5 last slot
    '{2'd1, 5'd0,  {1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,8'hFF}},            // R7 entry disabled
    '{2'd2, 5'd0,  {1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,5'd31}}   // R3 slot 0 reads ch 31
  };

  function automatic logic [7:0] lb(int f, int s, int c);
    return 8'((f * 7) + (s * 64) + (c * 5) + 1);
  endfunction

  function automatic logic [7:0] bb(int f, int s, int c);
    return lb(f, s, c) ^ 8'hA5 ^ 8'(s);
  endfunction

  function automatic logic [7:0] exp_out(logic [14:0] e, int c, int f, bit glob);
    int sa, ca, sf;
    logic [7:0] b;
    if (!glob || !e[14]) return 8'h00;
    if (e[13]) return e[7:0];
    sa = int'(e[6:5]);
    ca = int'(e[4:0]);
    sf = (e[11] || ca >= c) ? f - 1 : f;
    b = e[12] ? bb(sf, sa, ca) : lb(sf, sa, ca);
    if (e[10]) b = b & (8'h03 << (2 * int'(e[9:8])));
    return b;
  endfunction

  function automatic string tag_of(logic [14:0] e);
    if (!e[14]) return "R7";
    if (e[13])  return "R2";
    if (e[10])  return "R6";
    if (e[12])  return "R3";
    if (e[11])  return "R4";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_ch <= 0;
      tb_frame <= 0;
    end else if (tb_ch == NCH - 1) begin
      tb_ch <= 0;
      tb_frame <= tb_frame + 1;
    end else begin
      tb_ch <= tb_ch + 1;
    end
  end

  always @(negedge clk) begin
    for (int s = 0; s < NS; s++) begin
      loc_in[s*8 +: 8] = lb(tb_frame, s, tb_ch);
      bp_in[s*8 +: 8]  = bb(tb_frame, s, tb_ch);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cm_write(input int lane, input int ch, input logic [14:0] e);
    @(negedge clk);
    if (tb_ch == NCH - 1) @(negedge clk);
    cpu_we = 1'b1;
    cpu_addr = 7'((lane << 5) | ch);
    cpu_wdata = e;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic blk_write(input logic oe);
    @(negedge clk);
    if (tb_ch == NCH - 1) @(negedge clk);
    cpu_blk_we = 1'b1;
    cpu_wdata = {oe, 14'h0};
    @(negedge clk);
    cpu_blk_we = 1'b0;
  endtask

  task automatic ctl_write(input logic oe);
    @(negedge clk);
    cpu_ctl_we = 1'b1;
    cpu_ctl_oe = oe;
    @(negedge clk);
    cpu_ctl_we = 1'b0;
  endtask

  task automatic next_frame();
    do @(negedge clk); while (tb_ch != 0);
  endtask

  task automatic check_slot(input string tag, input int lane, input int c,
                            input logic [14:0] e, input bit glob);
    int f;
    do @(negedge clk); while (tb_ch != c);
    f = tb_frame;
    @(negedge clk);
    chk(tag, "data", int'(out_data[lane*8 +: 8]), int'(exp_out(e, c, f, glob)));
    chk(tag, "en", int'(out_en[lane]), int'(glob && e[14]));
    chk("R1", "out_ch", int'(out_ch), c);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] new_ent;
    logic [14:0] tmp;
    rst_n = 1'b0; ode_in = 1'b0; cpu_we = 1'b0; cpu_blk_we = 1'b0;
    cpu_ctl_we = 1'b0; cpu_ctl_oe = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    loc_in = '0; bp_in = '0;
    repeat (4) @(negedge clk);
    chk("R11", "out_en in reset", int'(out_en), 0);
    chk("R11", "out_data in reset", int'(out_data), 0);
    chk("R11", "out_ch in reset", int'(out_ch), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_en after reset", int'(out_en), 0);

    for (int i = 0; i < 10; i++) cm_write(int'(VECS[i].lane), int'(VECS[i].ch), VECS[i].ent);
    next_frame();
    next_frame();

    // R8: nothing drives while both enables are off
    check_slot("R8", 0, 5, VECS[0].ent, 1'b0);
    ctl_write(1'b1);

    for (int i = 0; i < 10; i++)
      check_slot(tag_of(VECS[i].ent), int'(VECS[i].lane), int'(VECS[i].ch), VECS[i].ent, 1'b1);

    // R9: write in slot 2, old entry still used in slot 5 of the same frame
    new_ent = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h77};
    do @(negedge clk); while (tb_ch != 2);
    cpu_we = 1'b1; cpu_addr = 7'd5; cpu_wdata = new_ent;
    @(negedge clk);
    cpu_we = 1'b0;
    check_slot("R9", 0, 5, VECS[0].ent, 1'b1);
    check_slot("R9", 0, 5, new_ent, 1'b1);

    // R8: software bit off, then external pin on
    ctl_write(1'b0);
    check_slot("R8", 0, 5, new_ent, 1'b0);
    @(negedge clk);
    ode_in = 1'b1;
    check_slot("R8", 0, 5, new_ent, 1'b1);

    // R10: block program clears and restores oe, other fields kept
    blk_write(1'b0);
    next_frame();
    tmp = new_ent; tmp[14] = 1'b0;
    check_slot("R10", 0, 5, tmp, 1'b1);
    tmp = VECS[3].ent; tmp[14] = 1'b0;
    check_slot("R10", 3, 10, tmp, 1'b1);
    blk_write(1'b1);
    next_frame();
    check_slot("R10", 0, 5, new_ent, 1'b1);
    check_slot("R10", 2, 25, VECS[6].ent, 1'b1);
    tmp = VECS[8].ent; tmp[14] = 1'b1;
    check_slot("R10", 1, 0, tmp, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule